// File: doc/BRIEF.md
# Masked condition-field LUT unit

This unit keeps a 32-bit condition register split into eight 4-bit fields and
applies truth-table logic to them, one field at a time. An operation names a
destination field and two further fields by 3-bit numbers. In ternary mode each
result bit is looked up in an 8-entry truth table given with the operation. The
index is formed from the matching bits of the destination and the two source
fields. In binary mode the index uses only the destination and the first source
field, and the second source field supplies the 4-entry table. Because the table
can come from a register field, the function can be chosen at run time.

The destination is both an input and the output, so every operation is a
read-modify-write of one field. A 4-bit write mask picks which of its bits are
replaced. A mask of all zeros is illegal: nothing is written and a one-cycle trap
pulse is raised. The whole register is visible on a read port at all times.

Top module: `cfl_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cr_out` is all zeros and `trap_o` is low.
- R2: Field n (0..7) occupies `cr_out[4*(7-n)+3 : 4*(7-n)]`, so field 0 is the top nibble. Bit i of a field is bit `4*(7-n)+i` of `cr_out`, and mask bit i and result bit i refer to it.
- R3: With `op_kind`=0 (ternary), result bit i is `tt_imm[4*D[i] + 2*A[i] + B[i]]`. Here D, A and B are the fields chosen by `dst_sel`, `srca_sel` and `srcb_sel`, and `tt_imm` bit 0 is its LSB.
- R4: With `op_kind`=1 (binary), result bit i is bit `2*D[i] + A[i]` of field B, which acts as a 4-entry table. `tt_imm` has no effect in this mode.
- R5: Only the destination bits whose `wr_mask` bit is 1 take the result. Every other bit of the register keeps its value.
- R6: When `op_valid` is high and `wr_mask` is 0, the register is unchanged and `trap_o` is high for exactly the following cycle. `trap_o` is never high otherwise.
- R7: All operands are read before the update. When field numbers coincide (for example destination equal to a source), every role sees the pre-update value.
- R8: While `op_valid` is low, the register holds its value and `trap_o` stays low.
- R9: The register changes on the clock edge that samples `op_valid`. Before that edge `cr_out` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute one operation at this edge |
| op_kind | input | 1 | 0 = ternary immediate table, 1 = binary table from a field |
| dst_sel | input | 3 | Destination field number (also first index bit) |
| srca_sel | input | 3 | First source field number |
| srcb_sel | input | 3 | Second source field number (table in binary mode) |
| tt_imm | input | 8 | Ternary truth table |
| wr_mask | input | 4 | Per-bit write enable for the destination field |
| cr_out | output | 32 | Whole condition register |
| trap_o | output | 1 | One-cycle illegal-operation pulse |

## Verification
The bench builds the unit with its default of eight fields, so the three 3-bit selectors span all 512 destination/source triples. The bench walks every triple in both modes. This covers all aliasing cases: the destination used as a source, the table field equal to an index field, and all three roles on one field. Masks are drawn at random from the full 4-bit range, zero included, and field contents are loaded through ordinary ternary operations with constant tables.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  // Width of one condition field; the binary mode indexes a 2-input table,
  // so this stays at 4.
  localparam int unsigned CFL_FIELD_W = 4;
  // Ternary truth-table width (three index bits).
  localparam int unsigned CFL_TT_W = 8;

  typedef enum logic {
    CFL_OP_TERN = 1'b0,
    CFL_OP_BIN  = 1'b1
  } cfl_op_e;

  // One bit of a 3-input lookup: destination bit is the index MSB.
  function automatic logic cfl_tern_bit(input logic [CFL_TT_W-1:0] tt,
                                        input logic d, input logic a,
                                        input logic b);
    return tt[{d, a, b}];
  endfunction

  // One bit of a 2-input lookup whose table is a whole field.
  function automatic logic cfl_bin_bit(input logic [CFL_FIELD_W-1:0] lut,
                                       input logic d, input logic a);
    return lut[{d, a}];
  endfunction

  // LSB position of field n in a register of nf fields (field 0 on top).
  function automatic int unsigned cfl_field_lsb(input int unsigned n,
                                                input int unsigned nf);
    return (nf - 1 - n) * CFL_FIELD_W;
  endfunction
endpackage

// File: rtl/cfl_field_sel.sv
module cfl_field_sel
  import cfl_pkg::*;
#(
  parameter  int unsigned NUM_FIELDS = 8,
  localparam int unsigned SEL_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned REG_W      = NUM_FIELDS * CFL_FIELD_W
) (
  input  logic [REG_W-1:0]       cr_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [CFL_FIELD_W-1:0] fld_o
);
  logic [CFL_FIELD_W-1:0] fields [NUM_FIELDS];

  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fld
    assign fields[n] = cr_i[cfl_field_lsb(n, NUM_FIELDS) +: CFL_FIELD_W];
  end

  always_comb begin
    fld_o = '0;
    for (int n = 0; n < NUM_FIELDS; n++) begin
      if (sel_i == SEL_W'(n)) fld_o = fields[n];
    end
  end
endmodule

// File: rtl/cfl_lut_core.sv
module cfl_lut_core
  import cfl_pkg::*;
(
  input  logic                   op_bin_i,
  input  logic [CFL_FIELD_W-1:0] dst_fld_i,
  input  logic [CFL_FIELD_W-1:0] srca_fld_i,
  input  logic [CFL_FIELD_W-1:0] srcb_fld_i,
  input  logic [CFL_TT_W-1:0]    tt_i,
  output logic [CFL_FIELD_W-1:0] res_o
);
  logic [CFL_FIELD_W-1:0] tern_res;
  logic [CFL_FIELD_W-1:0] bin_res;

  for (genvar i = 0; i < CFL_FIELD_W; i++) begin : g_bit
    assign tern_res[i] = cfl_tern_bit(tt_i, dst_fld_i[i], srca_fld_i[i],
                                      srcb_fld_i[i]);
    assign bin_res[i]  = cfl_bin_bit(srcb_fld_i, dst_fld_i[i], srca_fld_i[i]);
  end

  assign res_o = (cfl_op_e'(op_bin_i) == CFL_OP_BIN) ? bin_res : tern_res;
endmodule

// File: rtl/cfl_merge.sv
module cfl_merge
  import cfl_pkg::*;
#(
  parameter  int unsigned NUM_FIELDS = 8,
  localparam int unsigned SEL_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned REG_W      = NUM_FIELDS * CFL_FIELD_W
) (
  input  logic [REG_W-1:0]       cr_i,
  input  logic [SEL_W-1:0]       dst_sel_i,
  input  logic [CFL_FIELD_W-1:0] res_i,
  input  logic [CFL_FIELD_W-1:0] mask_i,
  input  logic                   wr_en_i,
  output logic [REG_W-1:0]       cr_next_o,
  output logic [REG_W-1:0]       wr_bits_o
);
  for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fld
    localparam int unsigned LSB = cfl_field_lsb(n, NUM_FIELDS);
    logic hit;
    assign hit = wr_en_i && (dst_sel_i == SEL_W'(n));
    for (genvar i = 0; i < CFL_FIELD_W; i++) begin : g_bit
      assign wr_bits_o[LSB+i] = hit & mask_i[i];
      assign cr_next_o[LSB+i] = wr_bits_o[LSB+i] ? res_i[i] : cr_i[LSB+i];
    end
  end
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit
  import cfl_pkg::*;
#(
  parameter  int unsigned NUM_FIELDS = 8,
  localparam int unsigned SEL_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int unsigned REG_W      = NUM_FIELDS * CFL_FIELD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic                   op_kind,
  input  logic [SEL_W-1:0]       dst_sel,
  input  logic [SEL_W-1:0]       srca_sel,
  input  logic [SEL_W-1:0]       srcb_sel,
  input  logic [CFL_TT_W-1:0]    tt_imm,
  input  logic [CFL_FIELD_W-1:0] wr_mask,
  output logic [REG_W-1:0]       cr_out,
  output logic                   trap_o
);
  logic [REG_W-1:0]       cr_q;
  logic                   trap_q;
  logic [CFL_FIELD_W-1:0] fld_dst;
  logic [CFL_FIELD_W-1:0] fld_a;
  logic [CFL_FIELD_W-1:0] fld_b;
  logic [CFL_FIELD_W-1:0] lut_res;
  logic [REG_W-1:0]       cr_next;
  logic [REG_W-1:0]       wr_bits;   // per-bit write event, used by checker
  logic                   op_write;  // legal operation this cycle
  logic                   op_illegal;// empty mask this cycle

  assign op_write   = op_valid && (wr_mask != '0);
  assign op_illegal = op_valid && (wr_mask == '0);

  // All three reads come from the pre-update register image.
  cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_sel_dst (
    .cr_i(cr_q), .sel_i(dst_sel), .fld_o(fld_dst));
  cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_sel_a (
    .cr_i(cr_q), .sel_i(srca_sel), .fld_o(fld_a));
  cfl_field_sel #(.NUM_FIELDS(NUM_FIELDS)) u_sel_b (
    .cr_i(cr_q), .sel_i(srcb_sel), .fld_o(fld_b));

  cfl_lut_core u_core (
    .op_bin_i  (op_kind),
    .dst_fld_i (fld_dst),
    .srca_fld_i(fld_a),
    .srcb_fld_i(fld_b),
    .tt_i      (tt_imm),
    .res_o     (lut_res)
  );

  cfl_merge #(.NUM_FIELDS(NUM_FIELDS)) u_merge (
    .cr_i     (cr_q),
    .dst_sel_i(dst_sel),
    .res_i    (lut_res),
    .mask_i   (wr_mask),
    .wr_en_i  (op_write),
    .cr_next_o(cr_next),
    .wr_bits_o(wr_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      cr_q   <= cr_next;
      trap_q <= op_illegal;
    end
  end

  assign cr_out = cr_q;
  assign trap_o = trap_q;
endmodule

// File: rtl/cfl_unit_chk.sv
module cfl_unit_chk #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned MASK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [MASK_W-1:0] wr_mask,
  input logic [REG_W-1:0]  cr_out,
  input logic              trap_o,
  input logic [REG_W-1:0]  wr_bits
);
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cr_out == '0) && !trap_o);

  p_trap_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_mask == '0) |=> trap_o);

  p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(op_valid && wr_mask == '0));

  p_zero_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_mask == '0) |=> $stable(cr_out));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cr_out) && !trap_o);

  p_mask_confine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((cr_out ^ $past(cr_out)) & ~$past(wr_bits)) == '0);

  p_mask_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $countones(wr_bits) == $countones(wr_mask));
endmodule

bind cfl_unit cfl_unit_chk #(.REG_W(REG_W), .MASK_W(cfl_pkg::CFL_FIELD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .wr_mask (wr_mask),
  .cr_out  (cr_out),
  .trap_o  (trap_o),
  .wr_bits (wr_bits)
);

// File: tb/cfl_unit_tb_top.sv
`timescale 1ns/1ps
module cfl_unit_tb_top;
  localparam int NF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_kind = 1'b0;
  logic [2:0]  dst_sel = '0, srca_sel = '0, srcb_sel = '0;
  logic [7:0]  tt_imm = '0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] cr_out;
  logic        trap_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model = '0;

  always #5 clk = ~clk;

  cfl_unit #(.NUM_FIELDS(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .tt_imm(tt_imm), .wr_mask(wr_mask), .cr_out(cr_out), .trap_o(trap_o));

  function automatic logic [3:0] get_f(input logic [31:0] cr, input int n);
    return 4'((cr >> (28 - 4 * n)) & 32'hF);
  endfunction

  // Reference: minterm sum for ternary, table read for binary.
  function automatic logic [31:0] ref_apply(input logic [31:0] cr,
      input logic kind, input int d, input int a, input int b,
      input logic [7:0] tt, input logic [3:0] m);
    logic [3:0] fd, fa, fb, nf;
    int sh;
    fd = get_f(cr, d); fa = get_f(cr, a); fb = get_f(cr, b);
    nf = fd;
    for (int i = 0; i < 4; i++) begin
      logic bit_v;
      bit_v = 1'b0;
      if (kind == 1'b0) begin
        for (int j = 0; j < 8; j++)
          if (tt[j] && (fd[i] == j[2]) && (fa[i] == j[1]) && (fb[i] == j[0]))
            bit_v = 1'b1;
      end else begin
        bit_v = fb[(fd[i] ? 2 : 0) + (fa[i] ? 1 : 0)];
      end
      if (m[i]) nf[i] = bit_v;
    end
    sh = 28 - 4 * d;
    return (cr & ~(32'hF << sh)) | (32'(nf) << sh);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic kind, input int d, input int a,
      input int b, input logic [7:0] tt, input logic [3:0] m,
      input string tag);
    logic [31:0] exp_cr;
    exp_cr = (m == 4'h0) ? model : ref_apply(model, kind, d, a, b, tt, m);
    @(negedge clk);
    op_valid = 1'b1; op_kind = kind;
    dst_sel = 3'(d); srca_sel = 3'(a); srcb_sel = 3'(b);
    tt_imm = tt; wr_mask = m;
    #2;
    chk(cr_out, model, {tag, " R9 before edge"});
    @(negedge clk);
    op_valid = 1'b0;
    chk(cr_out, exp_cr, tag);
    chk({31'h0, trap_o}, {31'h0, (m == 4'h0)}, {tag, " R6 trap"});
    model = exp_cr;
  endtask

  task automatic load_field(input int n, input logic [3:0] v);
    if (v != 4'h0) run_op(1'b0, n, 0, 0, 8'hFF, v, "R5 preload set");
    if (v != 4'hF) run_op(1'b0, n, 0, 0, 8'h00, ~v, "R5 preload clear");
  endtask

  task automatic randomize_reg();
    for (int n = 0; n < NF; n++) load_field(n, 4'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(cr_out, 32'h0, "R1 reset register");
    chk({31'h0, trap_o}, 32'h0, "R1 reset trap");
    rst_n = 1'b1;
    @(negedge clk);
    chk(cr_out, 32'h0, "R1 after release");

    // Layout: field 3 sits at bits 19:16.
    load_field(3, 4'hA);
    chk(cr_out, 32'h000A_0000, "R2 field 3 position");
    load_field(0, 4'h5);
    chk(cr_out, 32'h500A_0000, "R2 field 0 on top");

    // Ternary majority: fields 1=1100, 2=1010, 4=0110 -> 1110.
    load_field(1, 4'hC); load_field(2, 4'hA); load_field(4, 4'h6);
    run_op(1'b0, 1, 2, 4, 8'hE8, 4'hF, "R3 majority");
    chk(32'(get_f(cr_out, 1)), 32'hE, "R3 majority value");

    // Binary: table from field 5, tt_imm ignored.
    load_field(5, 4'h6); load_field(6, 4'h3); load_field(7, 4'h5);
    run_op(1'b1, 6, 7, 5, 8'hA5, 4'hF, "R4 xor via table");
    chk(32'(get_f(cr_out, 6)), 32'h6, "R4 xor value");
    run_op(1'b1, 6, 7, 5, 8'h00, 4'h3, "R4 tt ignored");
    run_op(1'b1, 6, 7, 5, 8'hFF, 4'hC, "R4 tt ignored alt");

    // Partial mask keeps unselected bits.
    load_field(2, 4'h0);
    run_op(1'b0, 2, 0, 0, 8'hFF, 4'h9, "R5 partial mask");
    chk(32'(get_f(cr_out, 2)), 32'h9, "R5 partial value");

    // Aliasing: all roles on one field.
    load_field(3, 4'h6);
    run_op(1'b0, 3, 3, 3, 8'h80, 4'hF, "R7 triple alias");
    run_op(1'b1, 5, 5, 5, 8'h00, 4'hF, "R7 binary alias");

    // Empty mask: trap, no write, trap lasts one cycle.
    run_op(1'b0, 0, 1, 2, 8'hFF, 4'h0, "R6 zero mask");
    @(negedge clk);
    chk({31'h0, trap_o}, 32'h0, "R6 trap one cycle");
    chk(cr_out, model, "R8 idle hold");
    op_valid = 1'b0; tt_imm = 8'hFF; wr_mask = 4'hF;
    repeat (2) @(negedge clk);
    chk(cr_out, model, "R8 idle with live inputs");

    // All field-number triples in both modes.
    for (int k = 0; k < 2; k++) begin
      for (int t = 0; t < NF * NF * NF; t++) begin
        logic [3:0] m;
        if ((t % 64) == 0) randomize_reg();
        m = ((t % 11) == 0) ? 4'h0 : 4'($urandom);
        run_op(k[0], t / 64, (t / 8) % 8, t % 8, 8'($urandom), m,
               k == 0 ? "R3 sweep" : "R4 sweep");
      end
    end

    // Free random ops.
    for (int r = 0; r < 400; r++)
      run_op(1'($urandom), int'($urandom % NF), int'($urandom % NF),
             int'($urandom % NF), 8'($urandom), 4'($urandom), "R7 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule